// File: doc/BRIEF.md
# Eight-Line GPIO Port with Address-Masked Data Access and Interrupts

This block is an eight-line general-purpose I/O port on a simple APB-style register bus. Each line is set to input or output on its own. Software reaches the data register through a window of addresses. The address bits inside that window choose which lines a read or a write touches. A driver can therefore change one line, or any group of lines, with a single store and no read-modify-write.

Every input passes through a two-stage synchroniser before any detection logic sees it. Each line can be set to raise an interrupt on a high level, a low level, a rising edge, a falling edge, or both edges. Edge events are latched until software acknowledges them by writing ones to a clear register. Level conditions are never latched. Per-line enables gate the raw status into a masked status. The OR of the masked bits leaves the block on a single registered interrupt pin.

The bus has no wait states. A write takes effect on the access-phase edge (`psel & penable & pwrite`). Read data is valid whenever `psel` is high. The address port carries the word address, which is byte address bits 11:2.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, every control register, the output latch and all status are zero: all lines are inputs, `pin_oe` is 0x00 and `irq` is 0.
- R2: Direction register (byte 0x400): bit n = 1 drives `pin_oe[n]` high, making line n an output. The register reads back as written.
- R3: A write to the data window (bytes 0x000 to 0x3FC) updates output bit n only when byte-address bit n+2 is 1. All other output bits keep their value.
- R4: A data-window read returns zero for every line whose byte-address bit n+2 is 0. A selected output line returns its output latch. A selected input line returns its synchronised pin level.
- R5: Sense register (byte 0x404) bit = 1 selects level detection. Event register (byte 0x40C) bit = 1 means high is active and 0 means low is active. Level status follows the synchronised input and is not latched.
- R6: Sense bit = 0 selects edge detection. Event bit = 1 means a rising edge and 0 means a falling edge. A detected edge sets a raw status bit (byte 0x414) that stays set.
- R7: Both-edges register (byte 0x408) bit = 1 makes any transition on an edge-sensed line set its status, whatever its event bit holds.
- R8: Writing 1 to bit n of the clear register (byte 0x41C) clears line n's latched edge. Zero bits have no effect. An edge arriving in the same cycle as its clear leaves the bit set.
- R9: Masked status (byte 0x418) equals raw status AND the enable register (byte 0x410). A cleared enable bit hides the line without erasing its raw status.
- R10: `irq` is the OR of the masked status bits, delayed by one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write (1) or read (0) |
| paddr | input | 10 | Word address (byte address bits 11:2) |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid while psel is high |
| pin_in | input | 8 | Asynchronous pad inputs |
| pin_out | output | 8 | Output latch value |
| pin_oe | output | 8 | Output enable per line |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The hardest situation to reach is a new edge that arrives in exactly the cycle when software writes that line's clear bit. From the pin, the edge needs two synchroniser stages before it is seen.

To get there, the bench moves the pin on the falling clock edge. It then starts a bus write so that the access-phase rising edge lands two clocks later, the same edge on which the edge detector fires. It then checks that the raw bit is still set.

The level-versus-latched behaviour is covered by toggling pins back and forth under each mode. The one-cycle lag of `irq` is covered by sampling both half a cycle after an enable write and one full cycle later.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       psel,
  input  logic       penable,
  input  logic       pwrite,
  input  logic [9:0] paddr,
  input  logic [7:0] pwdata,
  output logic [7:0] prdata,
  input  logic [7:0] pin_in,
  output logic [7:0] pin_out,
  output logic [7:0] pin_oe,
  output logic       irq
);
  localparam int N = 8;

  logic [N-1:0] out_q, dir_q, sense_q, both_q, event_q, ena_q, edge_q;
  logic [N-1:0] s1_q, s2_q, prev_q;
  logic         irq_q;

  wire wr      = psel & penable & pwrite;
  wire in_win  = (paddr[9:8] == 2'b00);
  wire [N-1:0] lane = paddr[7:0];
  wire ctl     = (paddr[9:8] == 2'b01);
  wire wr_data = wr & in_win;
  wire wr_dir  = wr & ctl & (lane == 8'h00);
  wire wr_sns  = wr & ctl & (lane == 8'h01);
  wire wr_both = wr & ctl & (lane == 8'h02);
  wire wr_evt  = wr & ctl & (lane == 8'h03);
  wire wr_ena  = wr & ctl & (lane == 8'h04);
  wire [N-1:0] clr = (wr & ctl & (lane == 8'h07)) ? pwdata : '0;

  wire [N-1:0] rise  = s2_q & ~prev_q;
  wire [N-1:0] fall  = ~s2_q & prev_q;
  wire [N-1:0] hit   = ~sense_q & ((both_q & (rise | fall)) |
                                   (~both_q & event_q & rise) |
                                   (~both_q & ~event_q & fall));
  wire [N-1:0] lvl   = sense_q & ~(s2_q ^ event_q);
  wire [N-1:0] raw   = lvl | (~sense_q & edge_q);
  wire [N-1:0] msk   = raw & ena_q;
  wire [N-1:0] view  = (dir_q & out_q) | (~dir_q & s2_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0; dir_q <= '0; sense_q <= '0; both_q <= '0;
      event_q <= '0; ena_q <= '0; edge_q <= '0;
      s1_q <= '0; s2_q <= '0; prev_q <= '0; irq_q <= 1'b0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (wr_data) out_q   <= (out_q & ~lane) | (pwdata & lane);
      if (wr_dir)  dir_q   <= pwdata;
      if (wr_sns)  sense_q <= pwdata;
      if (wr_both) both_q  <= pwdata;
      if (wr_evt)  event_q <= pwdata;
      if (wr_ena)  ena_q   <= pwdata;
      edge_q <= (edge_q & ~clr) | hit;
      irq_q  <= |msk;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      if (in_win) prdata = view & lane;
      else if (ctl) begin
        case (lane)
          8'h00:   prdata = dir_q;
          8'h01:   prdata = sense_q;
          8'h02:   prdata = both_q;
          8'h03:   prdata = event_q;
          8'h04:   prdata = ena_q;
          8'h05:   prdata = raw;
          8'h06:   prdata = msk;
          default: prdata = '0;
        endcase
      end
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = irq_q;

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pin_oe == $past(pwdata)); // R2
  AST_UNSELECTED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (pin_out & ~$past(lane)) == ($past(pin_out) & ~$past(lane))); // R3
  AST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && in_win) |-> (prdata & ~lane) == '0); // R4
  AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_q & ~clr)) & ~edge_q) == '0); // R8
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ena_q) != '0); // R10
endmodule

// File: tb/tb_gpio_mask_port.sv
`timescale 1ns/1ps
module tb_gpio_mask_port;
  logic       clk = 0, rst_n = 0;
  logic       psel = 0, penable = 0, pwrite = 0;
  logic [9:0] paddr = '0;
  logic [7:0] pwdata = '0, prdata, pin_in = '0, pin_out, pin_oe;
  logic       irq;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  gpio_mask_port dut (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  localparam logic [9:0] A_DIR = 10'h100, A_SNS = 10'h101, A_BOTH = 10'h102,
    A_EVT = 10'h103, A_ENA = 10'h104, A_RAW = 10'h105, A_MSK = 10'h106, A_CLR = 10'h107;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    #1 d = prdata;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(A_DIR, v); check("R1 dir", v, 8'h00);
    rd(A_ENA, v); check("R1 ena", v, 8'h00);
    rd(A_RAW, v); check("R1 raw", v, 8'h00);
    check("R1 oe", pin_oe, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_dir();
    logic [7:0] v;
    wr(A_DIR, 8'h0F);
    check("R2 oe", pin_oe, 8'h0F);
    rd(A_DIR, v); check("R2 readback", v, 8'h0F);
  endtask

  task automatic t_masked_write();
    wr(10'h0FF, 8'hFF); check("R3 all lanes", pin_out, 8'hFF);
    wr(10'h005, 8'h00); check("R3 lanes 0,2", pin_out, 8'hFA);
    wr(10'h000, 8'h00); check("R3 no lanes", pin_out, 8'hFA);
  endtask

  task automatic t_masked_read();
    logic [7:0] v;
    pin_in = 8'h50; settle();
    rd(10'h0FF, v); check("R4 full", v, 8'h5A);
    rd(10'h030, v); check("R4 partial", v, 8'h10);
    pin_in = 8'h00; settle();
    wr(A_DIR, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] v;
    wr(A_EVT, 8'h01); wr(A_SNS, 8'h03); settle();
    rd(A_RAW, v); check("R5 low active", v & 8'h03, 8'h02);
    pin_in = 8'h01; settle();
    rd(A_RAW, v); check("R5 both active", v & 8'h03, 8'h03);
    wr(A_ENA, 8'h01); settle();
    check("R10 level irq", {7'd0, irq}, 8'h01);
    pin_in = 8'h03; pin_in = 8'h02; settle();
    rd(A_RAW, v); check("R5 not latched", v & 8'h03, 8'h00);
    check("R10 irq drop", {7'd0, irq}, 8'h00);
    pin_in = 8'h00;
    wr(A_ENA, 8'h00); wr(A_SNS, 8'h00); wr(A_EVT, 8'h00); settle();
    wr(A_CLR, 8'hFF);
  endtask

  task automatic t_edge();
    logic [7:0] v;
    wr(A_EVT, 8'h04); wr(A_CLR, 8'hFF);
    pin_in = 8'h04; settle(); pin_in = 8'h00; settle();
    rd(A_RAW, v); check("R6 rising latched", v & 8'h0C, 8'h04);
    pin_in = 8'h08; settle();
    rd(A_RAW, v); check("R6 rise ignored on falling line", v & 8'h0C, 8'h04);
    pin_in = 8'h00; settle();
    rd(A_RAW, v); check("R6 falling latched", v & 8'h0C, 8'h0C);
    wr(A_CLR, 8'h00);
    rd(A_RAW, v); check("R8 zero clear", v & 8'h0C, 8'h0C);
    wr(A_CLR, 8'h04);
    rd(A_RAW, v); check("R8 clear one", v & 8'h0C, 8'h08);
    wr(A_CLR, 8'hFF);
  endtask

  task automatic t_both();
    logic [7:0] v;
    wr(A_BOTH, 8'h10);
    pin_in = 8'h10; settle();
    rd(A_RAW, v); check("R7 rise", v & 8'h10, 8'h10);
    wr(A_CLR, 8'h10);
    rd(A_RAW, v); check("R8 cleared", v & 8'h10, 8'h00);
    pin_in = 8'h00; settle();
    rd(A_RAW, v); check("R7 fall", v & 8'h10, 8'h10);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    rd(A_MSK, v); check("R9 masked hidden", v, 8'h00);
    check("R10 no irq while masked", {7'd0, irq}, 8'h00);
    rd(A_RAW, v); check("R9 raw kept", v & 8'h10, 8'h10);
    wr(A_ENA, 8'h10);
    check("R10 irq one cycle late", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R10 irq set", {7'd0, irq}, 8'h01);
    rd(A_MSK, v); check("R9 masked shown", v, 8'h10);
    wr(A_ENA, 8'h00); wr(A_BOTH, 8'h00); wr(A_CLR, 8'hFF);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    wr(A_EVT, 8'h20); wr(A_CLR, 8'hFF);
    @(negedge clk); pin_in = 8'h20;
    @(negedge clk); psel = 1; pwrite = 1; paddr = A_CLR; pwdata = 8'h20;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    rd(A_RAW, v); check("R8 edge beats clear", v & 8'h20, 8'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_dir(); t_masked_write(); t_masked_read();
    t_level(); t_edge(); t_both(); t_mask(); t_collision();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule